// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block supplies the word address for every beat of a four-beat burst on a synchronous memory port. A load cycle captures a complete external address. Its two low bits become the start point of the burst. Each later advance cycle moves the low bits one step further through the burst. The upper bits stay as they were captured.

Two step orders are available through a static select input. The linear order counts up modulo four from the start value. The interleaved order XORs the start value with a running beat number. In both orders the fifth beat returns to the start value.

A stall input freezes the whole block at a clock edge. A qualifier input marks which edges carry a real command. Command decoding and the memory array belong to the surrounding logic.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset is released, cur_addr is all zeros.
- R2: At an edge with stall=0, valid=1 and step=0 (load), the whole of ext_addr is captured, and cur_addr equals it from that edge on.
- R3: With order_il=0, each edge with stall=0, valid=1 and step=1 (advance) makes the two low bits of cur_addr one more than before, modulo 4.
- R4: With order_il=1, after n advances since the last load the two low bits of cur_addr equal the loaded low bits XOR (n mod 4).
- R5: In either order, the fourth advance after a load returns cur_addr to the loaded address.
- R6: At an edge with stall=1, cur_addr does not change, whatever valid, step and ext_addr carry.
- R7: At an edge with valid=0 and stall=0, cur_addr does not change, even when step=0 and ext_addr differs.
- R8: An advance never changes bits AW-1..2 of cur_addr, and ext_addr is ignored on advance edges.
- R9: A load in the middle of a burst restarts the beat count, so the next advance yields the new start value plus one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | 1: the edge is ignored and all state is held |
| valid | input | 1 | 1: this edge carries a load or advance command |
| step | input | 1 | 0: load ext_addr, 1: advance the burst |
| order_il | input | 1 | 0: linear order, 1: interleaved order |
| ext_addr | input | AW | External address taken on load |
| cur_addr | output | AW | Address of the current beat |

## Verification
The assertions assume that order_il is a static strap. It may change only on a load edge, where the beat number is zero and both orders give the same address. Its value is never changed during a stall, an idle edge or an advance. The bench follows this rule: it switches the order only in the same cycle as a load. Every other input, including ext_addr on advance and stalled edges, is free to take any value.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 16,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          valid,
  input  logic          step,
  input  logic          order_il,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cur_addr
);
  localparam int UW = AW - BW;

  logic [UW-1:0] upper_q;
  logic [BW-1:0] start_q;
  logic [BW-1:0] beat_q;
  logic [BW-1:0] low_lin;
  logic [BW-1:0] low_il;

  wire take = valid & ~stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (take) begin
      if (!step) begin
        upper_q <= ext_addr[AW-1:BW];
        start_q <= ext_addr[BW-1:0];
        beat_q  <= '0;
      end else begin
        beat_q  <= beat_q + 1'b1;
      end
    end
  end

  assign low_lin  = start_q + beat_q;
  assign low_il   = start_q ^ beat_q;
  assign cur_addr = {upper_q, order_il ? low_il : low_lin};
endmodule

module burst_addr_gen_chk #(
  parameter int AW = 16,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          valid,
  input logic          step,
  input logic          order_il,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] cur_addr
);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && valid && !step) |=> cur_addr == $past(ext_addr));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && valid && step && !order_il) |=>
      cur_addr[BW-1:0] == BW'($past(cur_addr[BW-1:0]) + 1'b1));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(cur_addr));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !valid) |=> $stable(cur_addr));

  // R8
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && valid && step) |=> $stable(cur_addr[AW-1:BW]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .valid(valid), .step(step),
  .order_il(order_il), .ext_addr(ext_addr), .cur_addr(cur_addr)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int BW = 2;

  typedef struct {
    logic [AW-1:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic          valid = 1'b0;
  logic          step = 1'b0;
  logic          order_il = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;

  int n_run = 0;
  int n_fail = 0;
  item_t sb_q[$];

  logic [AW-1:BW] m_upper = '0;
  logic [BW-1:0]  m_start = '0;
  logic [BW-1:0]  m_beat = '0;

  burst_addr_gen #(.AW(AW), .BW(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .valid(valid), .step(step),
    .order_il(order_il), .ext_addr(ext_addr), .cur_addr(cur_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if (cur_addr !== it.exp) begin
        n_fail++;
        $display("FAIL %s: cur_addr=%h expected=%h", it.tag, cur_addr, it.exp);
      end
    end
  end

  task automatic drive(input logic s, input logic v, input logic st,
                       input logic o, input logic [AW-1:0] a, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    stall = s; valid = v; step = st; order_il = o; ext_addr = a;
    if (!s && v) begin
      if (!st) begin
        m_upper = a[AW-1:BW];
        m_start = a[BW-1:0];
        m_beat  = '0;
      end else begin
        m_beat = m_beat + 1'b1;
      end
    end
    @(posedge clk);
    it.exp = {m_upper, o ? (m_start ^ m_beat) : BW'(m_start + m_beat)};
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: expired, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (cur_addr !== '0) begin
      n_fail++;
      $display("FAIL R1: cur_addr=%h expected=%h", cur_addr, 16'h0);
    end
    drive(0, 0, 1, 0, 16'hFFFF, "R7 idle after reset");

    drive(0, 1, 0, 0, 16'h1232, "R2 load linear");
    drive(0, 1, 1, 0, 16'h0000, "R3 linear beat1");
    drive(0, 1, 1, 0, 16'hFFFF, "R3 linear beat2 wrap low");
    drive(0, 1, 1, 0, 16'h5555, "R8 linear beat3 upper fixed");
    drive(0, 1, 1, 0, 16'h0000, "R5 linear fifth returns start");

    drive(0, 1, 0, 1, 16'h0A51, "R2 load interleaved");
    drive(0, 1, 1, 1, 16'h0000, "R4 interleave beat1");
    drive(0, 1, 1, 1, 16'h0000, "R4 interleave beat2");
    drive(0, 1, 1, 1, 16'hABCD, "R4 interleave beat3");
    drive(0, 1, 1, 1, 16'h0000, "R5 interleave fifth returns start");

    drive(0, 1, 1, 1, 16'h0000, "R4 interleave next burst beat1");
    drive(1, 1, 0, 1, 16'hBEEF, "R6 stall with load");
    drive(1, 1, 1, 1, 16'h0000, "R6 stall with advance");
    drive(0, 0, 0, 1, 16'hCAFE, "R7 invalid load ignored");
    drive(0, 1, 1, 1, 16'h0000, "R4 interleave beat2 after holds");

    drive(0, 1, 0, 0, 16'h7771, "R2 load linear start1");
    drive(0, 1, 1, 0, 16'h0000, "R3 linear beat1");
    drive(0, 1, 0, 0, 16'h7773, "R9 reload mid burst");
    drive(0, 1, 1, 0, 16'h1234, "R9 advance after reload");
    drive(0, 1, 1, 0, 16'h0000, "R3 linear after reload");

    drive(0, 0, 1, 0, 16'h0000, "R7 final idle");
    @(negedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule